// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host-facing side of a device's control space. A byte-wide bus with only two address lines reaches four direct locations: an index pointer, a data window into a bank of 37 byte-wide internal registers, a status location, and a programmed-I/O data location. The host first writes a register number to the pointer and then reads or writes the selected register through the data window. The pointer keeps its value between accesses, so repeated accesses to one register need no new pointer write.

The programmed-I/O location means different things depending on direction. A write there hands a byte to the playback path and raises a one-cycle push strobe. A read there returns the byte the capture path presents and raises a one-cycle pop strobe. A write to the status location raises a one-cycle strobe that other blocks use to clear their interrupt flags. Reads of the status location return a status byte that another block supplies. The whole register bank is also presented flat on an output, so that the rest of the device can use the settings. The data FIFOs and the codec datapath sit outside this block.

Top module: `irp_port`

## Requirements
- R1: After reset the pointer is 0, every bank register is 0x00, `host_rdata_o` and `play_data_o` are 0x00 and all three strobes are low.
- R2: A write to address 0 loads the pointer from the low 6 bits of the written byte, and the upper bits are dropped. The pointer changes on no other access. A read of address 0 returns the pointer zero-extended to 8 bits.
- R3: A write to address 1 while the pointer is below 37 stores the byte in bank register `pointer`. The new value appears on `regs_o` bits [8*p+7:8*p] after the write edge, and a later read of address 1 returns it.
- R4: With the pointer in 37..63, a read of address 1 returns 0x00 and a write to address 1 leaves every bank register unchanged.
- R5: A read of address 2 returns `status_i`. A write to address 2 sets `stat_wr_o` high for exactly the one cycle after the write edge, and it changes neither the bank nor the pointer.
- R6: A write to address 3 sets `play_push_o` high for the one cycle after the write edge, with `play_data_o` equal to the written byte. A read of address 3 returns `cap_data_i` and sets `cap_pop_o` high for the one cycle after the read edge. A write never pops and a read never pushes.
- R7: Read data is registered. `host_rdata_o` takes its new value on the edge that samples `host_rd_i` and holds it until the next accepted read.
- R8: If `host_wr_i` and `host_rd_i` are both high in one cycle, the write is performed and the read is ignored. `host_rdata_o` does not change and `cap_pop_o` stays low.
- R9: `play_data_o` holds the last pushed byte until the next write to address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr_i | input | 2 | Direct location select: 0 pointer, 1 data window, 2 status, 3 programmed-I/O data |
| host_wr_i | input | 1 | Write request, one access per cycle high |
| host_rd_i | input | 1 | Read request, one access per cycle high |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Registered read data |
| status_i | input | 8 | Status byte returned on reads of address 2 |
| cap_data_i | input | 8 | Capture byte returned on reads of address 3 |
| play_data_o | output | 8 | Last byte pushed toward playback |
| play_push_o | output | 1 | One-cycle playback push strobe |
| cap_pop_o | output | 1 | One-cycle capture pop strobe |
| stat_wr_o | output | 1 | One-cycle status-write strobe |
| regs_o | output | 296 | Bank contents, register p in bits [8*p+7:8*p] |

## Verification
Embedded properties check on every cycle that each strobe follows an access of the matching kind and direction, and that a push carries the written byte. They also check that the pointer moves only on a pointer write, that an out-of-range window write leaves the bank untouched and that an out-of-range window read returns zero. A collision is covered too: when a read and a write coincide, neither a pop nor a change of read data may follow. Only the bench's sweeps show that every one of the 64 pointer values lands on the right register or on none. The bench also shows that values written survive unrelated traffic and that the read data holds across idle cycles.

// File: rtl/irp_pkg.sv
package irp_pkg;

  // Direct location codes on the two address lines
  localparam logic [1:0] SEL_INDEX  = 2'd0;
  localparam logic [1:0] SEL_WINDOW = 2'd1;
  localparam logic [1:0] SEL_STATUS = 2'd2;
  localparam logic [1:0] SEL_PIO    = 2'd3;

  // True when a pointer value names an existing bank register
  function automatic logic in_bank(input int unsigned idx, input int unsigned nreg);
    return idx < nreg;
  endfunction

  // Bit offset of register p inside the flat bank vector
  function automatic int unsigned reg_lsb(input int unsigned p, input int unsigned dw);
    return p * dw;
  endfunction

endpackage

// File: rtl/irp_decode.sv
module irp_decode
  import irp_pkg::*;
(
  input  logic       host_wr_i,
  input  logic       host_rd_i,
  input  logic [1:0] host_addr_i,
  output logic [3:0] wr_ev_o,
  output logic [3:0] rd_ev_o
);

  // One event line per direct location; a write outranks a read
  always_comb begin
    wr_ev_o = '0;
    rd_ev_o = '0;
    if (host_wr_i)      wr_ev_o[host_addr_i] = 1'b1;
    else if (host_rd_i) rd_ev_o[host_addr_i] = 1'b1;
  end

endmodule

// File: rtl/irp_regbank.sv
module irp_regbank
  import irp_pkg::*;
#(
  parameter int NREG = 37,
  parameter int DW   = 8,
  parameter int IW   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rd_byte_o,
  output logic             hit_o,
  output logic [NREG*DW-1:0] regs_o
);

  logic [DW-1:0] bank_q [NREG];

  assign hit_o = in_bank(int'(idx_i), NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank_q[g] <= '0;
      else if (wr_en_i && idx_i == IW'(g))
        bank_q[g] <= wdata_i;
    end
    assign regs_o[reg_lsb(g, DW) +: DW] = bank_q[g];
  end

  always_comb begin
    rd_byte_o = '0;
    for (int i = 0; i < NREG; i++)
      if (idx_i == IW'(i)) rd_byte_o = bank_q[i];
  end

  // R4: a write with the pointer outside the bank changes nothing
  p_oor_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !hit_o) |=> $stable(regs_o));

  // R3: an in-range write lands in the addressed register
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && hit_o) |=> (rd_byte_o == $past(wdata_i) || $changed(idx_i)));

endmodule

// File: rtl/irp_port.sv
module irp_port
  import irp_pkg::*;
#(
  parameter int NREG = 37,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         host_addr_i,
  input  logic               host_wr_i,
  input  logic               host_rd_i,
  input  logic [DW-1:0]      host_wdata_i,
  output logic [DW-1:0]      host_rdata_o,
  input  logic [DW-1:0]      status_i,
  input  logic [DW-1:0]      cap_data_i,
  output logic [DW-1:0]      play_data_o,
  output logic               play_push_o,
  output logic               cap_pop_o,
  output logic               stat_wr_o,
  output logic [NREG*DW-1:0] regs_o
);

  localparam int IW = $clog2(NREG);

  // Named internal events
  logic [3:0]    wr_ev, rd_ev;
  logic          any_rd;
  logic          win_hit;
  logic [DW-1:0] win_byte;
  logic [DW-1:0] rd_mux;

  logic [IW-1:0] idx_q;
  logic [DW-1:0] rdata_q, play_q;
  logic          push_q, pop_q, stw_q;

  irp_decode u_dec (
    .host_wr_i  (host_wr_i),
    .host_rd_i  (host_rd_i),
    .host_addr_i(host_addr_i),
    .wr_ev_o    (wr_ev),
    .rd_ev_o    (rd_ev)
  );

  irp_regbank #(.NREG(NREG), .DW(DW), .IW(IW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_ev[SEL_WINDOW]),
    .idx_i    (idx_q),
    .wdata_i  (host_wdata_i),
    .rd_byte_o(win_byte),
    .hit_o    (win_hit),
    .regs_o   (regs_o)
  );

  assign any_rd = |rd_ev;

  always_comb begin
    unique case (host_addr_i)
      SEL_INDEX:  rd_mux = DW'(idx_q);
      SEL_WINDOW: rd_mux = win_hit ? win_byte : '0;
      SEL_STATUS: rd_mux = status_i;
      default:    rd_mux = cap_data_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      rdata_q <= '0;
      play_q  <= '0;
      push_q  <= 1'b0;
      pop_q   <= 1'b0;
      stw_q   <= 1'b0;
    end else begin
      if (wr_ev[SEL_INDEX]) idx_q   <= host_wdata_i[IW-1:0];
      if (any_rd)           rdata_q <= rd_mux;
      if (wr_ev[SEL_PIO])   play_q  <= host_wdata_i;
      push_q <= wr_ev[SEL_PIO];
      pop_q  <= rd_ev[SEL_PIO];
      stw_q  <= wr_ev[SEL_STATUS];
    end
  end

  assign host_rdata_o = rdata_q;
  assign play_data_o  = play_q;
  assign play_push_o  = push_q;
  assign cap_pop_o    = pop_q;
  assign stat_wr_o    = stw_q;

  // R2: the pointer moves only on a pointer write
  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_i && host_addr_i == SEL_INDEX) |=> $stable(idx_q));

  // R5: status strobe only follows a status write
  p_stat_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_o |-> $past(host_wr_i && host_addr_i == SEL_STATUS));

  // R6: push follows a data-port write and carries its byte
  p_push_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    play_push_o |-> ($past(host_wr_i && host_addr_i == SEL_PIO) && play_data_o == $past(host_wdata_i)));

  // R6/R8: pop only follows a lone data-port read
  p_pop_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pop_o |-> $past(host_rd_i && !host_wr_i && host_addr_i == SEL_PIO));

  // R8: a colliding read leaves the read data alone
  p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_i && host_rd_i) |=> $stable(host_rdata_o));

  // R4: an out-of-range window read yields zero
  p_oor_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && !host_wr_i && host_addr_i == SEL_WINDOW && !win_hit) |=> host_rdata_o == '0);

  // R9: the playback byte holds when nothing is pushed
  p_play_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_i && host_addr_i == SEL_PIO) |=> $stable(play_data_o));

endmodule

// File: tb/irp_port_test.sv
module irp_port_test;

  localparam int NREG = 37;
  localparam int DW   = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         host_addr_i = '0;
  logic               host_wr_i = 1'b0;
  logic               host_rd_i = 1'b0;
  logic [DW-1:0]      host_wdata_i = '0;
  logic [DW-1:0]      host_rdata_o;
  logic [DW-1:0]      status_i = '0;
  logic [DW-1:0]      cap_data_i = '0;
  logic [DW-1:0]      play_data_o;
  logic               play_push_o, cap_pop_o, stat_wr_o;
  logic [NREG*DW-1:0] regs_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] mdl [NREG];
  logic [5:0] mdl_idx;

  always #5 clk = ~clk;

  irp_port #(.NREG(NREG), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr_i(host_addr_i), .host_wr_i(host_wr_i),
    .host_rd_i(host_rd_i), .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .status_i(status_i), .cap_data_i(cap_data_i), .play_data_o(play_data_o),
    .play_push_o(play_push_o), .cap_pop_o(cap_pop_o), .stat_wr_o(stat_wr_o),
    .regs_o(regs_o)
  );

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + 5) ^ 8'hA5);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int p = 0; p < NREG; p++) chk(req, 32'(regs_o[p*8 +: 8]), 32'(mdl[p]));
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr_i = a; host_wdata_i = d; host_wr_i = 1'b1;
    @(negedge clk);
    host_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr_i = a; host_rd_i = 1'b1;
    @(negedge clk);
    host_rd_i = 1'b0;
    d = host_rdata_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int p = 0; p < NREG; p++) mdl[p] = 8'h00;
    mdl_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", 32'(host_rdata_o), 0);
    chk("R1 play_data", 32'(play_data_o), 0);
    chk("R1 strobes", {29'd0, play_push_o, cap_pop_o, stat_wr_o}, 0);
    chk_bank("R1 bank");
    rd(2'd0, v); chk("R1 pointer", 32'(v), 0);

    // R2 pointer load sweep over every byte value
    for (int b = 0; b < 256; b++) begin
      wr(2'd0, 8'(b));
      rd(2'd0, v);
      chk("R2 pointer readback", 32'(v), 32'(b & 63));
    end

    // R3 / R4 write sweep over all 64 pointer values
    for (int i = 0; i < 64; i++) begin
      wr(2'd0, 8'(i));
      wr(2'd1, pat(i, 1));
      if (i < NREG) begin
        mdl[i] = pat(i, 1);
        chk("R3 regs_o byte", 32'(regs_o[i*8 +: 8]), 32'(pat(i, 1)));
      end else begin
        chk_bank("R4 out-of-range write");
      end
    end
    // read-back sweep
    for (int i = 0; i < 64; i++) begin
      wr(2'd0, 8'(i));
      rd(2'd1, v);
      chk(i < NREG ? "R3 window read" : "R4 window read zero",
          32'(v), i < NREG ? 32'(pat(i, 1)) : 0);
    end
    // R2 pointer held across repeated window accesses
    wr(2'd0, 8'd20);
    wr(2'd1, 8'h3C); mdl[20] = 8'h3C;
    rd(2'd1, v); chk("R2 pointer held read", 32'(v), 32'h3C);
    rd(2'd0, v); chk("R2 pointer held", 32'(v), 20);
    mdl_idx = 6'd20;

    // R5 status read and write strobe
    status_i = 8'h96;
    rd(2'd2, v); chk("R5 status read", 32'(v), 32'h96);
    wr(2'd2, 8'hFF);
    chk("R5 stat_wr high", 32'(stat_wr_o), 1);
    chk("R5 no push", 32'(play_push_o), 0);
    @(negedge clk);
    chk("R5 stat_wr one cycle", 32'(stat_wr_o), 0);
    chk_bank("R5 bank untouched");
    rd(2'd0, v); chk("R5 pointer untouched", 32'(v), 32'(mdl_idx));

    // R6 push / pop with several bytes
    for (int k = 0; k < 8; k++) begin
      wr(2'd3, pat(k, 7));
      chk("R6 push high", 32'(play_push_o), 1);
      chk("R6 push data", 32'(play_data_o), 32'(pat(k, 7)));
      chk("R6 write no pop", 32'(cap_pop_o), 0);
      @(negedge clk);
      chk("R6 push one cycle", 32'(play_push_o), 0);
      chk("R9 play_data holds", 32'(play_data_o), 32'(pat(k, 7)));
      cap_data_i = pat(k, 9);
      rd(2'd3, v);
      chk("R6 capture read", 32'(v), 32'(pat(k, 9)));
      chk("R6 pop high", 32'(cap_pop_o), 1);
      chk("R6 read no push", 32'(play_push_o), 0);
      @(negedge clk);
      chk("R6 pop one cycle", 32'(cap_pop_o), 0);
    end
    // R9 play data survives other writes
    wr(2'd1, 8'h11); mdl[20] = 8'h11;
    wr(2'd2, 8'h00);
    chk("R9 play_data after other writes", 32'(play_data_o), 32'(pat(7, 7)));

    // R7 read data held across idle cycles and input changes
    status_i = 8'h5A;
    rd(2'd2, v);
    status_i = 8'hC3; cap_data_i = 8'h77;
    repeat (4) @(negedge clk);
    chk("R7 rdata held", 32'(host_rdata_o), 32'h5A);

    // R8 collision on the data port: push, no pop, rdata held
    @(negedge clk);
    host_addr_i = 2'd3; host_wdata_i = 8'hE1; host_wr_i = 1'b1; host_rd_i = 1'b1;
    @(negedge clk);
    host_wr_i = 1'b0; host_rd_i = 1'b0;
    chk("R8 collision push", 32'(play_push_o), 1);
    chk("R8 collision no pop", 32'(cap_pop_o), 0);
    chk("R8 collision rdata", 32'(host_rdata_o), 32'h5A);
    chk("R8 collision data", 32'(play_data_o), 32'hE1);
    // R8 collision on the window: write performed
    @(negedge clk);
    host_addr_i = 2'd1; host_wdata_i = 8'h4B; host_wr_i = 1'b1; host_rd_i = 1'b1;
    @(negedge clk);
    host_wr_i = 1'b0; host_rd_i = 1'b0;
    mdl[20] = 8'h4B;
    chk("R8 window write done", 32'(regs_o[20*8 +: 8]), 32'h4B);
    chk("R8 window rdata held", 32'(host_rdata_o), 32'h5A);
    chk_bank("R3 final bank");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule